// File: doc/BRIEF.md
# Strobed Parallel Port with Capture Latch

This block is an 8-bit bidirectional parallel port that sits behind a small register bus. Each pin has its own direction bit. A pin set as an output is driven from an output register. A pin set as an input is read live through the data register. A separate strobe input is synchronised into the clock domain. When the strobe makes a transition in the selected direction, the block copies the pin values into a capture register and raises a strobe flag.

Software acknowledges a capture with a two-step sequence. First it reads the status register while the flag is set, then it reads the capture register. Only that pair of reads, in that order, clears the flag. A new strobe edge that arrives between the two reads leaves the flag set, so no capture is lost. An optional three-state mode lets the strobe level itself enable the output buffers of pins that are configured as inputs.

The register map uses a 2-bit address:
- 0: data register (pins or output register).
- 1: direction register.
- 2: capture register, read-only.
- 3: status and control register. Bit 7 is the flag (read-only). Bit 1 enables three-state mode. Bit 0 selects the edge: 1 for rising, 0 for falling.

Top module: `spp_port`

## Requirements
- R1: After reset the direction, output and control registers are 0, the capture register is 0, the flag is 0, and every pin_oe bit is 0.
- R2: With three-state mode off, pin_oe equals the direction register (1 = output, 0 = input), and pin_out always carries the output register written at address 0.
- R3: A read of address 0 returns the output register for bits whose direction is 1 and the live pin_in value for bits whose direction is 0.
- R4: An active strobe edge copies pin_in into the capture register and sets the flag. Both become visible after the third rising clock edge that follows the strobe change, and not after the second.
- R5: A read of address 2 returns the value captured at the most recent active edge, even after pin_in has changed.
- R6: Status bit 0 selects the active edge, 1 for rising and 0 for falling. The opposite edge changes neither the flag nor the capture register.
- R7: A status read that sees the flag set, followed by a capture-register read, clears the flag.
- R8: A capture-register read that does not follow a status read with the flag set leaves the flag set.
- R9: An active edge that occurs between the status read and the capture read cancels the pending clear, so the flag stays set.
- R10: With status bit 1 set, pins whose direction bit is 0 have pin_oe at 1 while the synchronised strobe is at its active level (high for rising select, low for falling select). Output pins keep pin_oe at 1.
- R11: flag_out always equals status bit 7 as read at address 3, and writes to address 2 or to status bit 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read qualifier; triggers read side effects |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Output register driven towards the pads |
| pin_oe | output | 8 | Per-pin output-buffer enable |
| strobe_in | input | 1 | Asynchronous capture strobe |
| flag_out | output | 1 | Strobe flag |

## Verification
The assertions check the following on every cycle:
- The flag only rises in the cycle after a detected edge.
- The flag only falls after a capture read that was armed, with no edge in the same cycle.
- The capture register changes only on an edge.
- An armed clear never exists without the flag.
- Output enables follow the direction register whenever three-state mode is off.

Only the bench scenarios can show the following:
- The exact three-cycle latency from the strobe pin.
- The ordering of the two reads and the cancellation of a clear by a new edge.
- The ignored opposite edge and the held capture value.
- The strobe-gated enables of the three-state mode.

// File: rtl/spp_pkg.sv
package spp_pkg;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned RISE_BIT = 0;
    localparam int unsigned TRI_BIT  = 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA  = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_CAPT  = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/spp_edge_det.sv
module spp_edge_det #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    input  logic rise_sel,
    output logic strobe_lvl,
    output logic edge_hit
);
    localparam int unsigned SH_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic prev_lvl;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SH_W-2:0], strobe_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_lvl = st_q.sh[SYNC_STAGES-1];
    assign prev_lvl   = st_q.sh[SYNC_STAGES];
    assign edge_hit   = rise_sel ? (strobe_lvl & ~prev_lvl) : (~strobe_lvl & prev_lvl);

    // R6
    edge_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |-> (strobe_lvl == rise_sel));
endmodule

// File: rtl/spp_capture.sv
module spp_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_hit,
    input  logic [W-1:0] pins,
    input  logic         stat_rd,
    input  logic         capt_rd,
    output logic [W-1:0] capt,
    output logic         flag
);
    typedef struct packed {
        logic [W-1:0] capt;
        logic         flag;
        logic         arm;
    } capt_state_t;

    capt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_hit) begin
            st_d.capt = pins;
            st_d.flag = 1'b1;
            st_d.arm  = 1'b0;
        end else if (capt_rd && st_q.arm) begin
            st_d.flag = 1'b0;
            st_d.arm  = 1'b0;
        end else if (stat_rd) begin
            st_d.arm  = st_q.flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign capt = st_q.capt;
    assign flag = st_q.flag;

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(edge_hit));
    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(capt_rd && st_q.arm && !edge_hit));
    // R5
    capt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_hit |=> $stable(st_q.capt));
    // R9
    arm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.arm |-> st_q.flag);
endmodule

// File: rtl/spp_port.sv
module spp_port #(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   addr,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    input  logic         strobe_in,
    output logic         flag_out
);
    import spp_pkg::*;

    localparam int unsigned FLAG_BIT = W - 1;

    typedef struct packed {
        logic [W-1:0] outr;
        logic [W-1:0] dir;
        logic         tri_en;
        logic         rise;
    } port_state_t;

    port_state_t st_d, st_q;
    reg_sel_e    sel;
    logic        strobe_lvl, edge_hit, strobe_act, flag;
    logic [W-1:0] capt, data_view, stat_word;

    assign sel = reg_sel_e'(addr);

    spp_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in),
        .rise_sel(st_q.rise), .strobe_lvl(strobe_lvl), .edge_hit(edge_hit)
    );

    spp_capture #(.W(W)) i_capt (
        .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .pins(pin_in),
        .stat_rd(rd_en && sel == SEL_STAT), .capt_rd(rd_en && sel == SEL_CAPT),
        .capt(capt), .flag(flag)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (sel)
                SEL_DATA: st_d.outr = wdata;
                SEL_DIR:  st_d.dir  = wdata;
                SEL_STAT: begin
                    st_d.rise   = wdata[RISE_BIT];
                    st_d.tri_en = wdata[TRI_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_act = (strobe_lvl == st_q.rise);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign data_view[i] = st_q.dir[i] ? st_q.outr[i] : pin_in[i];
        assign pin_oe[i]    = st_q.dir[i] | (st_q.tri_en & strobe_act);
    end

    always_comb begin
        stat_word           = '0;
        stat_word[FLAG_BIT] = flag;
        stat_word[TRI_BIT]  = st_q.tri_en;
        stat_word[RISE_BIT] = st_q.rise;
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: rdata = data_view;
            SEL_DIR:  rdata = st_q.dir;
            SEL_CAPT: rdata = capt;
            SEL_STAT: rdata = stat_word;
            default:  rdata = '0;
        endcase
    end

    assign pin_out  = st_q.outr;
    assign flag_out = flag;

    // R2
    oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.tri_en |-> (pin_oe == st_q.dir));
    // R10
    oe_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & st_q.dir) == st_q.dir));
endmodule

// File: tb/test_spp_port.sv
module test_spp_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, strobe_in = 1'b0;
    logic [7:0] wdata = '0, pin_in = '0;
    logic [7:0] rdata, pin_out, pin_oe;
    logic       flag_out;
    int checks = 0, errs = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spp_port i_spp_port (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .strobe_in(strobe_in), .flag_out(flag_out));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic strobe(input logic v);
        @(negedge clk); strobe_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - errs, checks);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 out", pin_out, 8'h00);
        chk("R1 flag", {7'b0, flag_out}, 8'h00);
        rd(2'd1, v); chk("R1 dir", v, 8'h00);
        rd(2'd3, v); chk("R1 stat", v, 8'h00);
        rd(2'd2, v); chk("R1 capt", v, 8'h00);

        // R2 R3 sweep over every direction value
        wr(2'd0, 8'h3C);
        pin_in = 8'hC9;
        for (int d = 0; d < 256; d++) begin
            wr(2'd1, d[7:0]);
            chk("R2 oe", pin_oe, d[7:0]);
            chk("R2 out", pin_out, 8'h3C);
            rd(2'd0, v);
            chk("R3 data", v, (d[7:0] & 8'h3C) | (~d[7:0] & 8'hC9));
        end
        wr(2'd1, 8'h00);

        // R6 rising edge ignored in falling mode
        pin_in = 8'h11;
        strobe(1'b1);
        chk("R6 ignored flag", {7'b0, flag_out}, 8'h00);
        rd(2'd2, v); chk("R6 ignored capt", v, 8'h00);

        // R4 latency: falling edge, flag after third clock, not second
        pin_in = 8'hA5;
        @(negedge clk); strobe_in = 1'b0;
        repeat (2) @(posedge clk); #1;
        chk("R4 not yet", {7'b0, flag_out}, 8'h00);
        @(posedge clk); #1;
        chk("R4 flag set", {7'b0, flag_out}, 8'h01);
        @(negedge clk);
        pin_in = 8'h5A;
        rd(2'd2, v); chk("R5 capture held", v, 8'hA5);
        chk("R8 unarmed read keeps flag", {7'b0, flag_out}, 8'h01);
        rd(2'd3, v); chk("R11 stat bit7", v, 8'h80);
        rd(2'd2, v);
        chk("R7 cleared", {7'b0, flag_out}, 8'h00);
        rd(2'd3, v); chk("R11 stat cleared", v, 8'h00);

        // R11 writes to capture and flag bit ignored
        wr(2'd2, 8'hFF); rd(2'd2, v); chk("R11 capt write ignored", v, 8'hA5);
        wr(2'd3, 8'h80); rd(2'd3, v); chk("R11 flag write ignored", v, 8'h00);

        // R9 edge between status and capture read
        strobe(1'b1); strobe(1'b0);
        rd(2'd3, v); chk("R9 stat", v, 8'h80);
        pin_in = 8'h77;
        strobe(1'b1); strobe(1'b0);
        rd(2'd2, v); chk("R9 new capture", v, 8'h77);
        chk("R9 flag kept", {7'b0, flag_out}, 8'h01);
        rd(2'd3, v); rd(2'd2, v);
        chk("R7 cleared again", {7'b0, flag_out}, 8'h00);

        // R6 rising mode sweep of captures
        wr(2'd3, 8'h01);
        for (int k = 0; k < 16; k++) begin
            pin_in = 8'(k * 17 + 3);
            strobe(1'b1);
            chk("R6 rise flag", {7'b0, flag_out}, 8'h01);
            rd(2'd2, v); chk("R4 rise capture", v, 8'(k * 17 + 3));
            pin_in = 8'hEE;
            strobe(1'b0);
            rd(2'd2, v); chk("R6 falling ignored", v, 8'(k * 17 + 3));
            rd(2'd3, v); rd(2'd2, v);
            chk("R7 clear", {7'b0, flag_out}, 8'h00);
        end

        // R10 three-state mode, rising select: active high
        wr(2'd1, 8'h0F);
        wr(2'd3, 8'h03);
        chk("R10 inactive", pin_oe, 8'h0F);
        strobe(1'b1);
        chk("R10 active", pin_oe, 8'hFF);
        strobe(1'b0);
        chk("R10 back", pin_oe, 8'h0F);
        wr(2'd3, 8'h02);
        chk("R10 falling select low active", pin_oe, 8'hFF);
        wr(2'd3, 8'h00);
        chk("R2 tri off", pin_oe, 8'h0F);

        done = 1;
        summary();
    end
endmodule